// File: doc/BRIEF.md
# Bitmask Immediate Pattern Decoder

This block expands a compact 13-bit logical-immediate field into a full register constant. The field has three parts: a one-bit width flag, a six-bit run-length field and a six-bit rotate field. A width-select input chooses a 32-bit or a 64-bit destination.

The decoder first finds an element size from the flag and the run-length field. It then builds a run of ones inside that element and rotates the run right. Finally it tiles the element across the destination width. Reserved encodings produce a cleared valid flag and an all-zero value.

The result is registered once, so the value for a field presented before a rising edge appears at the outputs after that edge. Instruction fetch, the operation that consumes the constant and the reverse encoder are separate blocks.

Top module: `bmdec_top`

## Requirements
- R1: With `n_flag`=1, the element is 64 bits wide. The run length S is all six bits of `imms_i` and the rotation R is all six bits of `immr_i`.
- R2: With `n_flag`=0, the element size is the largest of 32, 16, 8, 4 and 2 whose selecting bit of `imms_i` is zero. Size 32 is selected by bit 5, 16 by bit 4, 8 by bit 3, 4 by bit 2 and 2 by bit 1. S and R are `imms_i` and `immr_i` reduced to their low log2(size) bits, so higher `immr_i` bits have no effect on the output.
- R3: The element holds ones in its lowest S+1 bit positions and zeros above them. It is rotated right by R within the element width, so element bit i equals the unrotated bit (i+R) mod size.
- R4: The rotated element repeats across the destination. With `wide_i`=1 it fills all 64 bits. With `wide_i`=0 it fills the low 32 bits and bits 63:32 of `value_o` are zero.
- R5: An encoding whose S bits, for the chosen size, are all ones is invalid. This includes `n_flag`=1 with `imms_i`=6'h3F.
- R6: With `n_flag`=0 and `imms_i[5:1]` all ones, no element size applies and the encoding is invalid.
- R7: With `wide_i`=0, any encoding with `n_flag`=1 is invalid.
- R8: For an invalid encoding, `valid_o` is 0 and `value_o` is all zeros. For a valid encoding, `value_o` is never zero.
- R9: The outputs are registered with one cycle of latency. While `rst_n` is low, `value_o` is zero and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| n_flag | input | 1 | Width flag of the immediate field (1 selects a 64-bit element) |
| imms_i | input | 6 | Run-length field, which also encodes the element size |
| immr_i | input | 6 | Rotate-right amount |
| wide_i | input | 1 | Destination width: 1 for 64 bits, 0 for 32 bits |
| value_o | output | 64 | Expanded constant; zero when the encoding is invalid |
| valid_o | output | 1 | 1 when the encoding is legal |

## Verification
The bench sweeps every value of the flag, run-length and rotate fields in both destination widths, which is 16384 patterns in total. Each result is compared with a loop-based reference taken one cycle later.

The patterns with `n_flag`=0 and upper rotate bits set separate correct masking of R from a decoder that uses the full rotate field. The all-ones run-length patterns, one for each element size, separate the reserved cases from the largest legal run. The narrow sweep with `n_flag`=1 separates the width rule from normal 64-bit decoding.

// File: rtl/bmdec_pkg.sv
package bmdec_pkg;
    localparam int FLD_W = 6;
    localparam int LEN_W = $clog2(FLD_W + 1);
    localparam int XLEN  = 1 << FLD_W;
    localparam int HALF  = XLEN / 2;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] val;
    } dec_res_t;
endpackage

// File: rtl/bmdec_size_sel.sv
module bmdec_size_sel
    import bmdec_pkg::*;
(
    input  logic             n_flag,
    input  logic [FLD_W-1:0] imms,
    output logic [LEN_W-1:0] len,
    output logic [FLD_W-1:0] s_val,
    output logic             ok
);
    logic [FLD_W:0] mask;
    logic           found;

    always_comb begin
        len   = '0;
        found = 1'b0;
        if (n_flag) begin
            len   = LEN_W'(FLD_W);
            found = 1'b1;
        end else begin
            for (int k = FLD_W - 1; k >= 1; k--) begin
                if (!found && !imms[k]) begin
                    len   = LEN_W'(k);
                    found = 1'b1;
                end
            end
        end
        mask  = (FLD_W+1)'((1 << len) - 1);
        s_val = imms & mask[FLD_W-1:0];
        ok    = found && (s_val != mask[FLD_W-1:0]);
    end
endmodule

// File: rtl/bmdec_pattern.sv
module bmdec_pattern
    import bmdec_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  logic [FLD_W-1:0] s_val,
    input  logic [FLD_W-1:0] immr,
    output logic [XLEN-1:0]  tiled
);
    logic [FLD_W:1][XLEN-1:0] pat;

    for (genvar L = 1; L <= FLD_W; L++) begin : g_size
        localparam int SZ = 1 << L;
        logic [XLEN-1:0] row;
        always_comb begin
            for (int i = 0; i < XLEN; i++) begin
                row[i] = (((i % SZ) + (int'(immr) % SZ)) % SZ) <= int'(s_val);
            end
        end
        assign pat[L] = row;
    end

    always_comb begin
        tiled = '0;
        for (int k = 1; k <= FLD_W; k++) begin
            if (len == LEN_W'(k)) tiled = pat[k];
        end
    end
endmodule

// File: rtl/bmdec_top.sv
module bmdec_top
    import bmdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             n_flag,
    input  logic [FLD_W-1:0] imms_i,
    input  logic [FLD_W-1:0] immr_i,
    input  logic             wide_i,
    output logic [XLEN-1:0]  value_o,
    output logic             valid_o
);
    logic [LEN_W-1:0] len;
    logic [FLD_W-1:0] s_val;
    logic             size_ok;
    logic [XLEN-1:0]  tiled;
    dec_res_t         res_d, res_q;

    bmdec_size_sel u_size (
        .n_flag (n_flag),
        .imms   (imms_i),
        .len    (len),
        .s_val  (s_val),
        .ok     (size_ok)
    );

    bmdec_pattern u_pat (
        .len    (len),
        .s_val  (s_val),
        .immr   (immr_i),
        .tiled  (tiled)
    );

    always_comb begin
        res_d.vld = size_ok && (wide_i || !n_flag);
        if (!res_d.vld)  res_d.val = '0;
        else if (wide_i) res_d.val = tiled;
        else             res_d.val = {{(XLEN-HALF){1'b0}}, tiled[HALF-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign value_o = res_q.val;
    assign valid_o = res_q.vld;

    p_bad_is_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> value_o == '0);
    p_good_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> value_o != '0);
    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> value_o[XLEN-1:HALF] == '0);
    p_narrow_n_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (n_flag && !wide_i) |=> !valid_o);
    p_full_run_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n_flag && imms_i == '1) |=> !valid_o);
    p_no_size_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_flag && imms_i[FLD_W-1:1] == '1) |=> !valid_o);
    p_plain_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (n_flag && wide_i && immr_i == '0 && imms_i != '1) |=>
        (valid_o && value_o == ((XLEN'(1) << ($past(imms_i) + 1)) - XLEN'(1))));
endmodule

// File: tb/bmdec_top_tb_top.sv
module bmdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        n_flag = 1'b0;
    logic [5:0]  imms_i = '0;
    logic [5:0]  immr_i = '0;
    logic        wide_i = 1'b0;
    logic [63:0] value_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bmdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .n_flag(n_flag), .imms_i(imms_i),
        .immr_i(immr_i), .wide_i(wide_i), .value_o(value_o), .valid_o(valid_o)
    );

    function automatic logic [64:0] ref_dec(bit n, bit [5:0] s6, bit [5:0] r6, bit wide);
        int size = 0;
        int s, r, regw;
        logic [63:0] el, rot, v;
        if (n) begin
            if (!wide) return '0;
            size = 64;
        end else begin
            for (int w = 32; w >= 2; w = w / 2) begin
                if (size == 0 && (int'(s6) & w) == 0) size = w;
            end
            if (size == 0) return '0;
        end
        s = int'(s6) & (size - 1);
        r = int'(r6) & (size - 1);
        if (s == size - 1) return '0;
        el = '0; rot = '0; v = '0;
        for (int i = 0; i < size; i++) el[i] = (i <= s);
        for (int i = 0; i < size; i++) rot[i] = el[(i + r) % size];
        regw = wide ? 64 : 32;
        for (int i = 0; i < regw; i++) v[i] = rot[i % size];
        return {1'b1, v};
    endfunction

    function automatic string tag_of(bit n, bit [5:0] s6, bit [5:0] r6, bit wide, bit vld);
        if (n && !wide) return "R7";
        if (!n && s6[5:1] == 5'h1F) return "R6";
        if (!vld) return "R5";
        if (n) return "R1";
        if (r6[5] && !s6[5]) return "R2";
        if (!wide) return "R4";
        return "R3";
    endfunction

    task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual valid=%0b value=%h expected valid=%0b value=%h",
                     tag, act[64], act[63:0], exp[64], exp[63:0]);
        end
    endtask

    initial begin
        logic [64:0] exp_q;
        string       tag_q;
        bit          pend = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check({valid_o, value_o} == 65'd0, "R9", {valid_o, value_o}, 65'd0);
        rst_n = 1'b1;
        for (int w = 0; w < 2; w++) begin
            for (int n = 0; n < 2; n++) begin
                for (int s = 0; s < 64; s++) begin
                    for (int r = 0; r < 64; r++) begin
                        @(negedge clk);
                        if (pend) begin
                            check({valid_o, value_o} == exp_q, tag_q, {valid_o, value_o}, exp_q);
                            // R8: invalid drives zero
                            if (!exp_q[64])
                                check(value_o == 64'd0, "R8", {valid_o, value_o}, exp_q);
                        end
                        wide_i = w[0]; n_flag = n[0]; imms_i = s[5:0]; immr_i = r[5:0];
                        exp_q = ref_dec(n[0], s[5:0], r[5:0], w[0]);
                        tag_q = tag_of(n[0], s[5:0], r[5:0], w[0], exp_q[64]);
                        pend = 1;
                    end
                end
            end
        end
        @(negedge clk);
        // R9: one-cycle latency on last pattern
        check({valid_o, value_o} == exp_q, "R9", {valid_o, value_o}, exp_q);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule